// File: doc/BRIEF.md
# Interleaved SECDED Block Decoder for Stored Configuration Data

This block sits between a flash reader and the configuration port of a large FPGA. The flash holds each configuration file as a series of protected blocks. Each block carries 1048 stored bits, of which 1024 are payload. Every stored bit is kept in complemented form, so the decoder flips each bit back before it checks anything.

Each block holds two interleaved SECDED codewords of 524 bits. One codeword carries the even stream bits and the other carries the odd stream bits. The decoder accumulates both syndromes while the 131 input bytes arrive. It then classifies the block and releases 128 corrected payload bytes, but only after the whole block has been checked.

When either codeword cannot be corrected, no payload is released. The decoder selects the redundant second copy and pulses a request, so the reader sends the same block again from that copy. If the second copy also fails, the decoder raises a fatal flag and stops accepting and releasing data until reset.

Top module: `flash_ecc_decoder`

## Requirements
- R1: Stream layout.
  - The input is 131 bytes. Stream bit k is bit k%8 of byte k/8 and is stored complemented.
  - Bit k belongs to half h=k%2 at position p=k/2, where p runs from 0 to 523.
  - In each half, position 0 is the overall parity and positions 1, 2, 4, …, 512 are Hamming check bits. Position 523 is a spare that encodes as 0.
  - The remaining positions hold data in ascending order. Payload bit j is data item j/2 of half j%2.
- R2: A block with no flipped bits yields 128 output bytes. Bit i of output byte b is payload bit 8b+i. No status pulse is raised.
- R3: A single flipped bit at any stream index k is corrected. This holds for data, check, parity or spare bits. The block gives one corr_pulse of one cycle, and corr_index reads k.
- R4: One flipped bit in each half is corrected. This gives one corr_pulse, corr_index reports the even (half 0) index, and corr_count advances by 2.
- R5: Two flipped bits in the same half of a primary-copy block produce an uncorr_pulse and a refetch_req pulse. copy_sel goes to 1, and no output byte is released for that block.
- R6: A correctable block that arrives while copy_sel is 1 is released normally. copy_sel returns to 0 after its last byte.
- R7: An uncorrectable block while copy_sel is 1 sets fatal. From then on in_ready and out_valid stay 0 until reset.
- R8: corr_count saturates at 2^CNT_W-1 and never wraps.
- R9: in_ready is 0 whenever out_valid is 1. A held output byte stays stable until out_ready is high.
- R10: After reset, in_ready is 1, out_valid, copy_sel and fatal are 0, and corr_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder accepts a byte |
| in_data | input | 8 | Stored (complemented) stream byte |
| out_valid | output | 1 | Corrected payload byte valid |
| out_ready | input | 1 | Downstream accepts a byte |
| out_data | output | 8 | Corrected payload byte |
| copy_sel | output | 1 | Copy to read: 0 primary, 1 redundant |
| refetch_req | output | 1 | One-cycle request to resend the block from the redundant copy |
| corr_pulse | output | 1 | One-cycle pulse: block needed correction |
| uncorr_pulse | output | 1 | One-cycle pulse: block uncorrectable |
| corr_index | output | 11 | Stream index of the last corrected bit |
| corr_count | output | CNT_W | Saturating count of corrected bits |
| fatal | output | 1 | Both copies of a block uncorrectable |

## Verification
Some rules are checked by assertions on every cycle:
- output hold under backpressure and the exclusion of input and output phases;
- that the correction and failure pulses never coincide;
- that a refetch always points at the redundant copy;
- that fatal stays set and silences both interfaces;
- that the counter holds at its ceiling and never decreases.

Only the bench scenarios can show that the decoded bytes match the payload. The bench encodes blocks with its own model and flips chosen or random bits. The scenarios also show:
- that corr_index names the flipped bit, including the parity and spare positions;
- that a double flip in one half triggers exactly one refetch with no output;
- that a second failure ends in the fatal state.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BLK_BYTES = 131;
  localparam int unsigned BLK_BITS  = BLK_BYTES * BYTE_W;
  localparam int unsigned PAY_BITS  = 1024;
  localparam int unsigned PAY_BYTES = PAY_BITS / BYTE_W;
  localparam int unsigned HALF_LEN  = BLK_BITS / 2;
  localparam int unsigned POS_W     = $clog2(HALF_LEN);
  localparam int unsigned IDX_W     = POS_W + 1;
  localparam int unsigned BCNT_W    = $clog2(BLK_BYTES);
  localparam int unsigned OCNT_W    = $clog2(PAY_BYTES);

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DECIDE  = 2'd1,
    ST_EMIT    = 2'd2,
    ST_FATAL   = 2'd3
  } dec_state_t;

  // Position inside a half of the d-th data item: skip 0, powers of two.
  function automatic int unsigned data_pos(input int unsigned d);
    int unsigned p;
    p = d + 3;
    for (int t = 2; t < int'(POS_W); t++) begin
      if (p >= (32'd1 << t)) p = p + 1;
    end
    return p;
  endfunction
endpackage

// File: rtl/fbe_rst_sync.sv
module fbe_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/fbe_collect.sv
module fbe_collect
  import fbe_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_i,
  input  logic [BYTE_W-1:0]         byte_i,
  output logic                      last_o,
  output logic [BLK_BITS-1:0]       blk_o,
  output logic [1:0][POS_W-1:0]     syn_o,
  output logic [1:0]                par_o
);
  logic [BCNT_W-1:0]     cnt_q, cnt_d;
  logic [1:0][POS_W-1:0] syn_q, syn_d;
  logic [1:0]            par_q, par_d;
  logic [BYTE_W-1:0]     mem_q [BLK_BYTES];
  logic [BYTE_W-1:0]     plain;

  assign plain  = ~byte_i;
  assign last_o = acc_i && (cnt_q == BCNT_W'(BLK_BYTES - 1));

  // Syndrome and parity of both halves, folded in one byte at a time.
  always_comb begin
    syn_d = syn_q;
    par_d = par_q;
    cnt_d = cnt_q;
    if (acc_i) begin
      if (cnt_q == '0) begin
        syn_d = '0;
        par_d = '0;
      end
      for (int i = 0; i < int'(BYTE_W); i++) begin
        if (plain[i]) begin
          syn_d[i % 2] = syn_d[i % 2] ^ ({cnt_q, 2'b00} + POS_W'(i / 2));
          par_d[i % 2] = ~par_d[i % 2];
        end
      end
      cnt_d = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      syn_q <= '0;
      par_q <= '0;
    end else if (acc_i) begin
      cnt_q <= cnt_d;
      syn_q <= syn_d;
      par_q <= par_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_i) mem_q[cnt_q] <= plain;
  end

  for (genvar g = 0; g < int'(BLK_BYTES); g++) begin : g_flat
    assign blk_o[g*BYTE_W +: BYTE_W] = mem_q[g];
  end

  assign syn_o = syn_q;
  assign par_o = par_q;

  AST_BYTE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= BCNT_W'(BLK_BYTES - 1)); // R1
endmodule

// File: rtl/fbe_emit.sv
module fbe_emit
  import fbe_pkg::*;
(
  input  logic [BLK_BITS-1:0]   blk_i,
  input  logic [1:0]            fix_en_i,
  input  logic [1:0][IDX_W-1:0] fix_idx_i,
  input  logic [OCNT_W-1:0]     sel_i,
  output logic [BYTE_W-1:0]     byte_o
);
  localparam logic [BLK_BITS-1:0] ONE = BLK_BITS'(1);

  logic [BLK_BITS-1:0] mask, fixed;
  logic [PAY_BITS-1:0] pay;

  always_comb begin
    mask = '0;
    for (int h = 0; h < 2; h++) begin
      if (fix_en_i[h]) mask = mask | (ONE << fix_idx_i[h]);
    end
  end

  assign fixed = blk_i ^ mask;

  for (genvar j = 0; j < int'(PAY_BITS); j++) begin : g_pay
    localparam int unsigned K = 2 * data_pos(j / 2) + (j % 2);
    assign pay[j] = fixed[K];
  end

  assign byte_o = pay[sel_i*BYTE_W +: BYTE_W];
endmodule

// File: rtl/flash_ecc_decoder.sv
module flash_ecc_decoder
  import fbe_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              copy_sel,
  output logic              refetch_req,
  output logic              corr_pulse,
  output logic              uncorr_pulse,
  output logic [10:0]       corr_index,
  output logic [CNT_W-1:0]  corr_count,
  output logic              fatal
);
  logic rst_n;
  fbe_rst_sync u_rs (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  logic                  acc, last;
  logic [BLK_BITS-1:0]   blk;
  logic [1:0][POS_W-1:0] syn;
  logic [1:0]            par;

  assign acc = in_valid && in_ready;

  fbe_collect u_col (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .byte_i(in_data),
    .last_o(last), .blk_o(blk), .syn_o(syn), .par_o(par)
  );

  // Per-half classification of the finished block.
  logic [1:0]            single, bad;
  logic [1:0][IDX_W-1:0] idx;

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      single[h] = par[h] && (syn[h] <= POS_W'(HALF_LEN - 1));
      bad[h]    = par[h] ? !single[h] : (syn[h] != '0);
      idx[h]    = {syn[h], 1'(h)};
    end
  end

  dec_state_t            st_q, st_d;
  logic [OCNT_W-1:0]     eb_q, eb_d;
  logic                  copy_q, copy_d;
  logic                  refetch_q, refetch_d;
  logic                  corr_q, corr_d;
  logic                  uncorr_q, uncorr_d;
  logic [IDX_W-1:0]      cidx_q, cidx_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [1:0]            fix_en_q, fix_en_d;
  logic [1:0][IDX_W-1:0] fix_idx_q, fix_idx_d;
  logic [CNT_W:0]        sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(single[0]) + (CNT_W+1)'(single[1]);

  always_comb begin
    st_d      = st_q;
    eb_d      = eb_q;
    copy_d    = copy_q;
    refetch_d = 1'b0;
    corr_d    = 1'b0;
    uncorr_d  = 1'b0;
    cidx_d    = cidx_q;
    cnt_d     = cnt_q;
    fix_en_d  = fix_en_q;
    fix_idx_d = fix_idx_q;
    unique case (st_q)
      ST_COLLECT: if (last) st_d = ST_DECIDE;
      ST_DECIDE: begin
        if (|bad) begin
          uncorr_d = 1'b1;
          if (!copy_q) begin
            copy_d    = 1'b1;
            refetch_d = 1'b1;
            st_d      = ST_COLLECT;
          end else begin
            st_d = ST_FATAL;
          end
        end else begin
          fix_en_d  = single;
          fix_idx_d = idx;
          eb_d      = '0;
          st_d      = ST_EMIT;
          if (|single) begin
            corr_d = 1'b1;
            cidx_d = single[0] ? idx[0] : idx[1];
            cnt_d  = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
          end
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          if (eb_q == OCNT_W'(PAY_BYTES - 1)) begin
            st_d   = ST_COLLECT;
            copy_d = 1'b0;
          end else begin
            eb_d = eb_q + 1'b1;
          end
        end
      end
      default: st_d = ST_FATAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_COLLECT;
      eb_q      <= '0;
      copy_q    <= 1'b0;
      refetch_q <= 1'b0;
      corr_q    <= 1'b0;
      uncorr_q  <= 1'b0;
      cidx_q    <= '0;
      cnt_q     <= '0;
      fix_en_q  <= '0;
      fix_idx_q <= '0;
    end else begin
      st_q      <= st_d;
      eb_q      <= eb_d;
      copy_q    <= copy_d;
      refetch_q <= refetch_d;
      corr_q    <= corr_d;
      uncorr_q  <= uncorr_d;
      cidx_q    <= cidx_d;
      cnt_q     <= cnt_d;
      fix_en_q  <= fix_en_d;
      fix_idx_q <= fix_idx_d;
    end
  end

  fbe_emit u_emit (
    .blk_i(blk), .fix_en_i(fix_en_q), .fix_idx_i(fix_idx_q),
    .sel_i(eb_q), .byte_o(out_data)
  );

  assign in_ready     = (st_q == ST_COLLECT);
  assign out_valid    = (st_q == ST_EMIT);
  assign fatal        = (st_q == ST_FATAL);
  assign copy_sel     = copy_q;
  assign refetch_req  = refetch_q;
  assign corr_pulse   = corr_q;
  assign uncorr_pulse = uncorr_q;
  assign corr_index   = cidx_q;
  assign corr_count   = cnt_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(corr_pulse && uncorr_pulse)); // R3
  AST_REFETCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    refetch_req |-> copy_sel && uncorr_pulse); // R5
  AST_FIX_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!fix_en_q[0] || !fix_idx_q[0][0]) && (!fix_en_q[1] || fix_idx_q[1][0])); // R4
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal); // R7
  AST_FATAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> !in_ready && !out_valid); // R7
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    &corr_count |=> &corr_count); // R8
  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    corr_count >= $past(corr_count)); // R8
endmodule

// File: tb/sim_flash_ecc_decoder.sv
`timescale 1ns/1ps
module sim_flash_ecc_decoder;
  localparam int CW = 4;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, copy_sel, refetch_req, corr_pulse, uncorr_pulse, fatal;
  logic [7:0] out_data;
  logic [10:0] corr_index;
  logic [CW-1:0] corr_count;

  always #4 clk = ~clk;

  flash_ecc_decoder #(.CNT_W(CW)) u0 (
    .clk(clk), .arst_n(arst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .copy_sel(copy_sel), .refetch_req(refetch_req),
    .corr_pulse(corr_pulse), .uncorr_pulse(uncorr_pulse),
    .corr_index(corr_index), .corr_count(corr_count), .fatal(fatal)
  );

  int n_chk = 0, n_fail = 0;
  int n_corr = 0, n_uncorr = 0, n_refetch = 0, rx_total = 0, last_idx = 0;
  logic [7:0] rx_mem [128];
  bit bp = 1'b0;
  bit overlap = 1'b0;

  always @(posedge clk) begin
    if (corr_pulse) begin n_corr++; last_idx = int'(corr_index); end
    if (uncorr_pulse) n_uncorr++;
    if (refetch_req) n_refetch++;
    if (out_valid && out_ready) begin
      rx_mem[rx_total % 128] = out_data;
      rx_total++;
    end
  end

  always @(negedge clk) begin
    out_ready <= bp ? 1'($urandom_range(0, 1)) : 1'b1;
    if (out_valid && in_ready) overlap = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference encoder: one half of 524 bits.
  function automatic logic [523:0] enc_half(input logic [511:0] dh);
    logic [523:0] c;
    int di;
    bit pr;
    c = '0;
    di = 0;
    for (int p = 1; p < 523; p++) begin
      if ((p & (p - 1)) != 0) begin c[p] = dh[di]; di++; end
    end
    for (int t = 0; t < 10; t++) begin
      pr = 1'b0;
      for (int p = 1; p < 524; p++) if (((p >> t) & 1) == 1) pr = pr ^ c[p];
      c[1 << t] = pr;
    end
    c[0] = ^c[523:1];
    return c;
  endfunction

  function automatic logic [1047:0] encode(input logic [1023:0] d);
    logic [511:0] d0, d1;
    logic [523:0] c0, c1;
    logic [1047:0] s;
    for (int i = 0; i < 512; i++) begin d0[i] = d[2*i]; d1[i] = d[2*i+1]; end
    c0 = enc_half(d0);
    c1 = enc_half(d1);
    for (int p = 0; p < 524; p++) begin s[2*p] = ~c0[p]; s[2*p+1] = ~c1[p]; end
    return s;
  endfunction

  function automatic logic [1023:0] rand_data();
    logic [1023:0] d;
    for (int i = 0; i < 32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  task automatic send(input logic [1047:0] s);
    int i;
    i = 0;
    while (i < 131) begin
      @(negedge clk);
      if (in_ready) begin in_valid = 1'b1; in_data = s[i*8 +: 8]; i++; end
      else in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done(input bit expect_out, input int base);
    for (int c = 0; c < 3000; c++) begin
      if (expect_out ? (rx_total >= base + 128 && in_ready) : (in_ready || fatal)) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic int data_mism(input logic [1023:0] d);
    int m;
    m = 0;
    for (int b = 0; b < 128; b++) if (rx_mem[b] !== d[b*8 +: 8]) m++;
    return m;
  endfunction

  // Runs one correctable block and checks payload, pulses, index, count.
  task automatic run_good(input string req, input logic [1023:0] d, input logic [1047:0] flips,
                          input int exp_pulses, input int exp_idx, input int exp_cnt);
    int b_rx, b_c;
    b_rx = rx_total; b_c = n_corr;
    send(encode(d) ^ flips);
    wait_done(1'b1, b_rx);
    chk(rx_total == b_rx + 128, req, "byte count", rx_total - b_rx, 128);
    chk(data_mism(d) == 0, req, "mismatched bytes", data_mism(d), 0);
    chk(n_corr - b_c == exp_pulses, req, "corr pulses", n_corr - b_c, exp_pulses);
    if (exp_pulses > 0) chk(last_idx == exp_idx, req, "corr_index", last_idx, exp_idx);
    chk(int'(corr_count) == exp_cnt, req, "corr_count", int'(corr_count), exp_cnt);
  endtask

  task automatic do_reset();
    arst_n = 1'b0;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R10", "in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R10", "out_valid", int'(out_valid), 0);
    chk(copy_sel == 1'b0, "R10", "copy_sel", int'(copy_sel), 0);
    chk(fatal == 1'b0, "R10", "fatal", int'(fatal), 0);
    chk(corr_count == '0, "R10", "corr_count", int'(corr_count), 0);
  endtask

  task automatic t_clean();
    int b_u;
    b_u = n_uncorr;
    run_good("R2", rand_data(), '0, 0, 0, 0);
    bp = 1'b1;
    run_good("R1", {32{32'hA5C3_0F96}}, '0, 0, 0, 0);
    run_good("R9", rand_data(), '0, 0, 0, 0);
    bp = 1'b0;
    chk(n_uncorr == b_u, "R2", "uncorr pulses", n_uncorr - b_u, 0);
    chk(!overlap, "R9", "in_ready during output", int'(overlap), 0);
  endtask

  task automatic t_single(inout int cnt);
    int ks[6];
    ks[0] = 0; ks[1] = 1047; ks[2] = 2;
    ks[3] = $urandom_range(0, 1047); ks[4] = $urandom_range(0, 1047); ks[5] = $urandom_range(0, 1047);
    foreach (ks[n]) begin
      cnt++;
      run_good("R3", rand_data(), 1048'(1) << ks[n], 1, ks[n], cnt);
    end
  endtask

  task automatic t_two_halves(inout int cnt);
    int ke, ko;
    ke = 2 * $urandom_range(0, 523);
    ko = 2 * $urandom_range(0, 523) + 1;
    cnt += 2;
    run_good("R4", rand_data(), (1048'(1) << ke) | (1048'(1) << ko), 1, ke, cnt);
  endtask

  task automatic t_refetch(input int cnt);
    logic [1023:0] d;
    int b_rx, b_u, b_r, k1, k2;
    d = rand_data();
    k1 = 2 * $urandom_range(0, 261);
    k2 = 2 * $urandom_range(262, 523);
    b_rx = rx_total; b_u = n_uncorr; b_r = n_refetch;
    send(encode(d) ^ (1048'(1) << k1) ^ (1048'(1) << k2));
    wait_done(1'b0, b_rx);
    chk(n_uncorr - b_u == 1, "R5", "uncorr pulses", n_uncorr - b_u, 1);
    chk(n_refetch - b_r == 1, "R5", "refetch pulses", n_refetch - b_r, 1);
    chk(copy_sel == 1'b1, "R5", "copy_sel", int'(copy_sel), 1);
    chk(rx_total == b_rx, "R5", "bytes released", rx_total - b_rx, 0);
    run_good("R6", d, '0, 0, 0, cnt);
    chk(copy_sel == 1'b0, "R6", "copy_sel after release", int'(copy_sel), 0);
  endtask

  task automatic t_saturate(inout int cnt);
    for (int n = 0; n < 12; n++) begin
      int k;
      k = $urandom_range(0, 1047);
      cnt = (cnt + 1 > SAT) ? SAT : cnt + 1;
      run_good("R8", rand_data(), 1048'(1) << k, 1, k, cnt);
    end
    chk(int'(corr_count) == SAT, "R8", "saturated count", int'(corr_count), SAT);
  endtask

  task automatic t_fatal();
    logic [1047:0] bad;
    int b_rx, b_u;
    bad = encode(rand_data()) ^ (1048'(1) << 9) ^ (1048'(1) << 701);
    b_rx = rx_total; b_u = n_uncorr;
    send(bad);
    wait_done(1'b0, b_rx);
    send(bad);
    wait_done(1'b0, b_rx);
    repeat (20) @(negedge clk);
    chk(fatal == 1'b1, "R7", "fatal", int'(fatal), 1);
    chk(in_ready == 1'b0, "R7", "in_ready", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R7", "out_valid", int'(out_valid), 0);
    chk(n_uncorr - b_u == 2, "R7", "uncorr pulses", n_uncorr - b_u, 2);
    chk(rx_total == b_rx, "R7", "bytes released", rx_total - b_rx, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    cnt = 0;
    do_reset();
    t_reset();
    t_clean();
    t_single(cnt);
    t_two_halves(cnt);
    t_refetch(cnt);
    t_saturate(cnt);
    t_fatal();
    do_reset();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule